// File: doc/BRIEF.md
# Fill-Word Elastic Retiming Buffer

This block carries 40-bit transmission words, each made of four 10b characters, from a recovered-clock domain into a local reference-clock domain. The write side takes one aligned word per write clock when the valid strobe is high. The read side gives out one word on every local clock, whether or not new data is present. The two clocks are nominally equal but may drift apart by a few hundred ppm. The buffer absorbs that drift by acting only on fill words. When the buffer runs high, the write side throws away an incoming fill word. When it runs low, the read side sends the fill word at the head again instead of moving past it. Data words are never thrown away and never sent twice.

The store holds eight words and aims to sit at four. The pointers cross between the domains as Gray codes through two-flop synchronizers. Each side works out its fill level from its own pointer and the synchronized copy of the other pointer.

The write side has two states. It stays in WS_OK until a data word arrives while the buffer is full. That transition, to WS_FAULT, loses the word, and the state holds until reset. The read side has two states. RS_PRIME sends out the configured fill word and moves to RS_RUN once the level reaches the target of four. RS_RUN takes words from the store and returns to RS_PRIME when the level reads zero. If that return comes straight after a data word was sent, the sticky underflow flag is set.

Top module: `fill_elastic_retimer`

## Requirements
- R1: While either reset is asserted, and right after both resets are released, the output word equals the configured fill word and both error flags are 0.
- R2: Data words (every word not equal to the fill word) leave the read side in the order they were written, with none lost and none repeated, as long as no overflow occurs.
- R3: When a valid fill word arrives and the write side sees a level of 6 or more, the word is not stored. A fill word is the only kind of word ever dropped this way.
- R4: In RS_RUN, when the word at the head is the fill word and the read side sees a level from 1 to 2, that fill word is sent out and the read pointer stays where it is. Data words at the head always advance.
- R5: In RS_PRIME, meaning after reset or after the buffer reads empty, the output is the configured fill word until the read side sees a level of at least 4.
- R6: A cycle with the write valid low stores nothing. While the store is empty the output keeps sending the configured fill word.
- R7: A valid data word that arrives when the write side sees 8 stored words sets the write-domain overflow flag, and the flag stays set until the write reset.
- R8: If RS_RUN finds the level at zero and the last word it sent was a data word, the read-domain underflow flag is set, and it stays set until the read reset.
- R9: The write pointer and the read pointer cross between the domains as Gray codes, and each changes by at most one bit per clock of its own domain.
- R10: A word counts as a fill word only if it matches the 40-bit FILL_WORD parameter exactly. The default is a K28.5 comma followed by three fixed data characters. A word that differs from it in one bit is handled as data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered clock, write domain |
| wr_rst_n | input | 1 | Write-domain reset, asynchronous, active low |
| wr_valid | input | 1 | Marks wr_word as a valid aligned word |
| wr_word | input | 40 | Incoming 10b-encoded transmission word |
| rd_clk | input | 1 | Local reference clock, read domain |
| rd_rst_n | input | 1 | Read-domain reset, asynchronous, active low |
| rd_word | output | 40 | Retimed output word, registered, one per rd_clk |
| wr_ovf_err | output | 1 | Sticky flag: a data word was lost to a full buffer |
| rd_udf_err | output | 1 | Sticky flag: a data stream ran dry mid-flow |

## Verification
A fault in either pointer or in the level arithmetic shows up at rd_word as a data word that is out of order, missing or repeated. The reference model catches this on the first rd_clk after the bad word is registered. A wrong decision about fill words shows up more slowly, over hundreds of words, as too few or too many fill words in the output. Under a steady rate offset it can also show up as a spurious error flag. The bench therefore runs long streams, with the write clock both faster and slower than the read clock, and compares fill counts as well as data order. A wrong priming threshold or a wrong sticky flag is visible within a few tens of cycles of a directed sequence.

// File: rtl/ebuf_pkg.sv
`timescale 1ns/1ps
// Shared types for the fill-word elastic retiming buffer.
package ebuf_pkg;

    // Write side: normal operation, or a data word has been lost.
    typedef enum logic {
        WS_OK    = 1'b0,
        WS_FAULT = 1'b1
    } wr_state_e;

    // Read side: priming with fill words, or draining the store.
    typedef enum logic {
        RS_PRIME = 1'b0,
        RS_RUN   = 1'b1
    } rd_state_e;

endpackage

// File: rtl/ebuf_ptr_sync.sv
`timescale 1ns/1ps
// Two-flop synchronizer for a Gray-coded pointer; gives back binary.
module ebuf_ptr_sync #(
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] gray_in,
    output logic [PW-1:0] bin_out
);

    logic [PW-1:0] meta_q;
    logic [PW-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= gray_in;
            sync_q <= meta_q;
        end
    end

    // Binary bit i is the parity of Gray bits i and above.
    for (genvar i = 0; i < PW; i++) begin : g_g2b
        assign bin_out[i] = ^(sync_q >> i);
    end

endmodule

// File: rtl/ebuf_store.sv
`timescale 1ns/1ps
// Word store: written on the write clock, read asynchronously by address.
module ebuf_store #(
    parameter int WORD_W = 40,
    parameter int DEPTH  = 8,
    parameter int AW     = 3
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rdata
);

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/ebuf_wr_ctrl.sv
`timescale 1ns/1ps
// Write-side control: stores words, drops fill words when the level is high.
module ebuf_wr_ctrl
    import ebuf_pkg::*;
#(
    parameter int                WORD_W    = 40,
    parameter int                AW        = 3,
    parameter int                DEPTH     = 8,
    parameter int                HI_MARK   = 6,
    parameter logic [WORD_W-1:0] FILL_WORD = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    input  logic [AW:0]       rptr_sync,
    output logic              we,
    output logic [AW-1:0]     waddr,
    output logic [WORD_W-1:0] wdata,
    output logic [AW:0]       wptr_gray,
    output logic              ovf_err
);

    localparam int            PW      = AW + 1;
    localparam logic [PW-1:0] HI_L    = PW'(HI_MARK);
    localparam logic [PW-1:0] DEPTH_L = PW'(DEPTH);

    wr_state_e     st_q, st_d;
    logic [PW-1:0] wptr_bin_q, wptr_bin_d;
    logic [PW-1:0] wptr_gray_q;
    logic [PW-1:0] level;
    logic          in_fill, full, drop_fill, store_it;

    assign level     = wptr_bin_q - rptr_sync;
    assign in_fill   = (in_word == FILL_WORD);
    assign full      = (level == DEPTH_L);
    assign drop_fill = in_fill && (level >= HI_L);
    assign store_it  = in_valid && !drop_fill && !full;

    // Next state: a data word meeting a full store moves to WS_FAULT.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            WS_OK:    if (in_valid && full && !in_fill) st_d = WS_FAULT;
            WS_FAULT: st_d = WS_FAULT;
        endcase
    end

    assign wptr_bin_d = wptr_bin_q + PW'(store_it);

    // State and pointer registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= WS_OK;
            wptr_bin_q  <= '0;
            wptr_gray_q <= '0;
        end else begin
            st_q        <= st_d;
            wptr_bin_q  <= wptr_bin_d;
            wptr_gray_q <= wptr_bin_d ^ (wptr_bin_d >> 1);
        end
    end

    // Outputs.
    always_comb begin
        we        = store_it;
        waddr     = wptr_bin_q[AW-1:0];
        wdata     = in_word;
        wptr_gray = wptr_gray_q;
        ovf_err   = (st_q == WS_FAULT);
    end

    // R3: a fill word seen at a high level leaves the pointer unchanged.
    p_drop_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_fill && level >= HI_L) |=> $stable(wptr_bin_q));

    // R2: a data word with room in the store always advances the pointer.
    p_keep_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_fill && level != DEPTH_L)
        |=> (wptr_bin_q == $past(wptr_bin_q) + PW'(1)));

    // R7: a data word at a full store raises the overflow flag.
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_fill && level == DEPTH_L) |=> ovf_err);

    // R7: the overflow flag is sticky.
    p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err |=> ovf_err);

    // R9: the Gray write pointer changes at most one bit per clock.
    p_wgray_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wptr_gray_q ^ $past(wptr_gray_q)) <= 1);

endmodule

// File: rtl/ebuf_rd_ctrl.sv
`timescale 1ns/1ps
// Read-side control: primes, drains, repeats fill words when the level is low.
module ebuf_rd_ctrl
    import ebuf_pkg::*;
#(
    parameter int                WORD_W    = 40,
    parameter int                AW        = 3,
    parameter int                TARGET    = 4,
    parameter int                LO_MARK   = 2,
    parameter logic [WORD_W-1:0] FILL_WORD = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW:0]       wptr_sync,
    input  logic [WORD_W-1:0] head_word,
    output logic [AW-1:0]     raddr,
    output logic [AW:0]       rptr_gray,
    output logic [WORD_W-1:0] out_word,
    output logic              udf_err
);

    localparam int            PW    = AW + 1;
    localparam logic [PW-1:0] TGT_L = PW'(TARGET);
    localparam logic [PW-1:0] LO_L  = PW'(LO_MARK);

    rd_state_e         st_q, st_d;
    logic [PW-1:0]     rptr_bin_q, rptr_bin_d;
    logic [PW-1:0]     rptr_gray_q;
    logic [PW-1:0]     level;
    logic [WORD_W-1:0] out_q, out_d;
    logic              udf_q, udf_d;
    logic              last_data_q, last_data_d;
    logic              adv;
    logic              head_fill;

    assign level     = wptr_sync - rptr_bin_q;
    assign head_fill = (head_word == FILL_WORD);

    // Next state and datapath decisions.
    always_comb begin
        st_d        = st_q;
        adv         = 1'b0;
        out_d       = FILL_WORD;
        udf_d       = udf_q;
        last_data_d = last_data_q;
        unique case (st_q)
            RS_PRIME: begin
                last_data_d = 1'b0;
                if (level >= TGT_L) st_d = RS_RUN;
            end
            RS_RUN: begin
                if (level == '0) begin
                    st_d        = RS_PRIME;
                    last_data_d = 1'b0;
                    if (last_data_q) udf_d = 1'b1;
                end else begin
                    out_d       = head_word;
                    last_data_d = !head_fill;
                    adv         = !(head_fill && level <= LO_L);
                end
            end
        endcase
    end

    assign rptr_bin_d = rptr_bin_q + PW'(adv);

    // State and datapath registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= RS_PRIME;
            rptr_bin_q  <= '0;
            rptr_gray_q <= '0;
            out_q       <= FILL_WORD;
            udf_q       <= 1'b0;
            last_data_q <= 1'b0;
        end else begin
            st_q        <= st_d;
            rptr_bin_q  <= rptr_bin_d;
            rptr_gray_q <= rptr_bin_d ^ (rptr_bin_d >> 1);
            out_q       <= out_d;
            udf_q       <= udf_d;
            last_data_q <= last_data_d;
        end
    end

    // Outputs.
    always_comb begin
        raddr     = rptr_bin_q[AW-1:0];
        rptr_gray = rptr_gray_q;
        out_word  = out_q;
        udf_err   = udf_q;
    end

    // R5: while priming, the next output word is the fill word.
    p_prime_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == RS_PRIME) |=> (out_word == FILL_WORD));

    // R4: a fill word at the head at a low level is repeated, not consumed.
    p_repeat_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == RS_RUN && level != '0 && level <= LO_L && head_fill)
        |=> ($stable(rptr_bin_q) && out_word == FILL_WORD));

    // R6: an empty store never moves the read pointer.
    p_empty_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (level == '0) |=> $stable(rptr_bin_q));

    // R8: running dry right after a data word raises the underflow flag.
    p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == RS_RUN && level == '0 && last_data_q) |=> udf_err);

    // R8: the underflow flag is sticky.
    p_udf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        udf_err |=> udf_err);

    // R9: the Gray read pointer changes at most one bit per clock.
    p_rgray_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rptr_gray_q ^ $past(rptr_gray_q)) <= 1);

endmodule

// File: rtl/fill_elastic_retimer.sv
`timescale 1ns/1ps
// Fill-word elastic retiming buffer: recovered clock in, local clock out.
module fill_elastic_retimer #(
    parameter int                WORD_W    = 40,
    parameter int                DEPTH     = 8,
    parameter int                TARGET    = 4,
    parameter int                HI_MARK   = 6,
    parameter int                LO_MARK   = 2,
    // K28.5 (negative disparity) followed by three fixed data characters.
    parameter logic [WORD_W-1:0] FILL_WORD = {10'b0011111010, 10'b1010101101,
                                              10'b1010101010, 10'b1010101010}
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_valid,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    output logic [WORD_W-1:0] rd_word,
    output logic              wr_ovf_err,
    output logic              rd_udf_err
);

    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic              we;
    logic [AW-1:0]     waddr, raddr;
    logic [WORD_W-1:0] wdata, head_word;
    logic [PW-1:0]     wptr_gray, rptr_gray;
    logic [PW-1:0]     wptr_in_rd, rptr_in_wr;

    ebuf_wr_ctrl #(
        .WORD_W(WORD_W), .AW(AW), .DEPTH(DEPTH),
        .HI_MARK(HI_MARK), .FILL_WORD(FILL_WORD)
    ) wr_ctrl_i (
        .clk(wr_clk), .rst_n(wr_rst_n),
        .in_valid(wr_valid), .in_word(wr_word),
        .rptr_sync(rptr_in_wr),
        .we(we), .waddr(waddr), .wdata(wdata),
        .wptr_gray(wptr_gray), .ovf_err(wr_ovf_err)
    );

    ebuf_store #(
        .WORD_W(WORD_W), .DEPTH(DEPTH), .AW(AW)
    ) store_i (
        .wclk(wr_clk), .we(we), .waddr(waddr), .wdata(wdata),
        .raddr(raddr), .rdata(head_word)
    );

    ebuf_ptr_sync #(.PW(PW)) wptr_sync_i (
        .clk(rd_clk), .rst_n(rd_rst_n),
        .gray_in(wptr_gray), .bin_out(wptr_in_rd)
    );

    ebuf_ptr_sync #(.PW(PW)) rptr_sync_i (
        .clk(wr_clk), .rst_n(wr_rst_n),
        .gray_in(rptr_gray), .bin_out(rptr_in_wr)
    );

    ebuf_rd_ctrl #(
        .WORD_W(WORD_W), .AW(AW), .TARGET(TARGET),
        .LO_MARK(LO_MARK), .FILL_WORD(FILL_WORD)
    ) rd_ctrl_i (
        .clk(rd_clk), .rst_n(rd_rst_n),
        .wptr_sync(wptr_in_rd), .head_word(head_word),
        .raddr(raddr), .rptr_gray(rptr_gray),
        .out_word(rd_word), .udf_err(rd_udf_err)
    );

endmodule

// File: tb/fill_elastic_retimer_tb_top.sv
`timescale 1ns/1ps
module fill_elastic_retimer_tb_top;

    localparam logic [39:0] FILL = {10'b0011111010, 10'b1010101101,
                                    10'b1010101010, 10'b1010101010};

    logic        wr_clk = 1'b0, rd_clk = 1'b0;
    logic        wr_rst_n = 1'b0, rd_rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [39:0] wr_word = '0;
    logic [39:0] rd_word;
    logic        wr_ovf_err, rd_udf_err;
    real         wr_half = 5.0;

    always #5 rd_clk = ~rd_clk;          // 100 MHz local clock
    always #(wr_half) wr_clk = ~wr_clk;  // recovered clock, variable

    fill_elastic_retimer #(.FILL_WORD(FILL)) dut_i (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_valid(wr_valid),
        .wr_word(wr_word), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n),
        .rd_word(rd_word), .wr_ovf_err(wr_ovf_err), .rd_udf_err(rd_udf_err)
    );

    int          checks = 0, errors = 0;
    bit          model_on = 1'b0, count_in = 1'b0, finished = 1'b0;
    logic [39:0] exp_q[$];
    int          fills_out = 0, fills_at_last = 0, fills_in = 0;
    int          seq = 0, near_k = 0;

    task automatic check(input bit ok, input string req,
                         input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Reference model: every output word is either the fill word or the
    // oldest data word not yet seen (R2, R10).
    always @(negedge rd_clk) begin
        if (model_on && rd_rst_n) begin
            if (rd_word == FILL) begin
                fills_out++;
                check(1'b1, "R2", rd_word, FILL);
            end else if (exp_q.size() > 0 && rd_word == exp_q[0]) begin
                void'(exp_q.pop_front());
                fills_at_last = fills_out;
                check(1'b1, "R2", rd_word, rd_word);
            end else begin
                check(1'b0, "R2 order/loss/duplicate", rd_word,
                      exp_q.size() > 0 ? exp_q[0] : FILL);
            end
        end
    end

    function automatic logic [39:0] next_data();
        seq++;
        if (seq % 7 == 0) begin
            near_k++;
            return FILL ^ (40'h1 << (near_k % 40));   // R10: one bit off fill
        end
        return {8'hC3, 32'(seq)};
    endfunction

    task automatic send(input logic [39:0] w);
        @(negedge wr_clk);
        wr_valid = 1'b1;
        wr_word  = w;
        if (w != FILL) exp_q.push_back(w);
        else if (count_in) fills_in++;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge wr_clk);
            wr_valid = 1'b0;
        end
    endtask

    task automatic do_reset(input real half);
        model_on = 1'b0;
        wr_valid = 1'b0;
        wr_rst_n = 1'b0;
        rd_rst_n = 1'b0;
        wr_half  = half;
        #40;
        // R1: values while held in reset
        check(rd_word == FILL, "R1 out in reset", rd_word, FILL);
        exp_q.delete();
        fills_out = 0; fills_at_last = 0; fills_in = 0;
        @(negedge wr_clk) wr_rst_n = 1'b1;
        @(negedge rd_clk) rd_rst_n = 1'b1;
        check(rd_word == FILL, "R1 out after reset", rd_word, FILL);
        check(!wr_ovf_err && !rd_udf_err, "R1 flags clear",
              {38'b0, wr_ovf_err, rd_udf_err}, '0);
        model_on = 1'b1;
    endtask

    task automatic stream(input int groups);
        count_in = 1'b1;
        repeat (groups) begin
            repeat (3) send(next_data());
            send(FILL);
        end
        count_in = 1'b0;
    endtask

    task automatic drain();
        repeat (24) send(FILL);
        idle(2);
        repeat (40) @(negedge rd_clk);
    endtask

    initial begin
        // R1, R6: reset state, then idle input gives only fill words.
        do_reset(5.0);
        idle(30);
        @(negedge rd_clk);
        check(rd_word == FILL, "R6 idle emits fill", rd_word, FILL);
        check(!rd_udf_err && !wr_ovf_err, "R6 idle no flag",
              {38'b0, wr_ovf_err, rd_udf_err}, '0);

        // R5: three words are below the target, so output stays fill.
        do_reset(5.0);
        send(next_data()); send(next_data()); send(next_data());
        idle(30);
        @(negedge rd_clk);
        check(rd_word == FILL, "R5 priming holds fill", rd_word, FILL);
        check(exp_q.size() == 3, "R5 nothing released below target",
              40'(exp_q.size()), 40'd3);
        send(FILL);                     // level reaches 4
        idle(40);
        @(negedge rd_clk);
        check(exp_q.size() == 0, "R5 released at target",
              40'(exp_q.size()), 40'd0);
        // R4: fill at head with low level is repeated indefinitely.
        check(rd_word == FILL, "R4 fill repeated at low level", rd_word, FILL);
        check(!rd_udf_err, "R4 repeat gives no underflow",
              {39'b0, rd_udf_err}, '0);

        // R3: write clock 5% fast; fill words must be dropped.
        do_reset(4.75);
        stream(500);
        drain();
        check(exp_q.size() == 0, "R2 fast stream delivered",
              40'(exp_q.size()), 40'd0);
        check(!wr_ovf_err, "R3 fast stream no overflow",
              {39'b0, wr_ovf_err}, '0);
        check(fills_at_last < fills_in, "R3 fill words deleted",
              40'(fills_at_last), 40'(fills_in));

        // R4: write clock 5% slow; fill words must be repeated.
        do_reset(5.25);
        stream(500);
        drain();
        check(exp_q.size() == 0, "R2 slow stream delivered",
              40'(exp_q.size()), 40'd0);
        check(!rd_udf_err, "R4 slow stream no underflow",
              {39'b0, rd_udf_err}, '0);
        check(fills_at_last > fills_in, "R4 fill words inserted",
              40'(fills_at_last), 40'(fills_in));

        // R7: write clock twice as fast with data only.
        do_reset(2.5);
        model_on = 1'b0;
        repeat (60) send(next_data());
        idle(4);
        check(wr_ovf_err, "R7 overflow flagged", {39'b0, wr_ovf_err}, 40'd1);
        idle(20);
        check(wr_ovf_err, "R7 overflow sticky", {39'b0, wr_ovf_err}, 40'd1);

        // R8: write clock half speed with data only.
        do_reset(10.0);
        repeat (40) send(next_data());
        idle(4);
        repeat (30) @(negedge rd_clk);
        check(rd_udf_err, "R8 underflow flagged", {39'b0, rd_udf_err}, 40'd1);
        check(exp_q.size() == 0, "R2 order kept through underflow",
              40'(exp_q.size()), 40'd0);
        check(!wr_ovf_err, "R7 no overflow when slow",
              {39'b0, wr_ovf_err}, '0);

        summary();
    end

    initial begin
        #1_500_000;
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        summary();
    end

endmodule